// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic read and write an external asynchronous static RAM of 64K words by 16 bits. The host presents a request pulse along with an address, a read/write flag, one strobe per byte lane and write data. The controller then runs a complete memory cycle on the active-low chip, write, output and lane-select pins. When the cycle ends, it returns a one-cycle ready pulse and, for reads, the registered data.

Every transfer follows a fixed sequence. In the setup cycle, address, lane selects and (for writes) data are driven. The strobe window follows, with the write or output strobe held low for a wait-state count derived from the access time and the clock period. In the release cycle the strobe is high again but address and data are still held. After that the controller returns to idle with the chip deselected. The bidirectional data bus is split into a data-out vector, a drive enable and a data-in vector. A pad cell or the memory model joins them.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every cycle with no transfer in progress, chip enable, write strobe, output strobe and both lane selects are high, the data drive enable is low and `rdy` is low.
- R2: The active strobe (write strobe for writes, output strobe for reads) stays low for exactly W cycles per transfer. W is ceil(ACCESS_PS / CLK_PS) with a minimum of 1, which gives 12 for the defaults.
- R3: For a write, chip enable is low and the data drive enable is high in the cycle before the write strobe falls. The write strobe rises one cycle before chip enable rises. The address stays unchanged while chip enable is low, and the output strobe stays high for the whole write.
- R4: For a read, the output strobe is low with the write strobe high. Data on `mem_dq_i` is captured at the clock edge that ends the strobe window. `rdy` is high for exactly one cycle, in the cycle right after that edge, and `rdata` is valid in the same cycle.
- R5: `req_be[0]` drives `mem_lane_n[0]` low and selects data bits 7:0. `req_be[1]` drives `mem_lane_n[1]` low and selects bits 15:8. A write changes only the selected lanes of the memory word.
- R6: In read results, bits of lanes that were not requested are zero. A write transfer completes with `rdata` equal to zero. A request with no lane strobes runs a cycle that changes no memory bit.
- R7: `mem_dq_oe` is high only while chip enable is low and the output strobe is high. The write and output strobes are never low in the same cycle.
- R8: A request is accepted only in an idle cycle, and one presented during a transfer is ignored. After each `rdy` pulse, chip enable is high for at least one cycle before the next transfer.
- R9: Seen at the falling edge, `rdy` first appears W+1 rising edges after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request pulse, sampled only in idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_be | input | 2 | Active-high lane strobes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, unrequested lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lane_n | output | 2 | Lane selects, active low: bit 0 low byte, bit 1 high byte |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The case that is hardest to reach from the ports is a request that arrives while a transfer is already under way. The controller must drop that request without disturbing the memory. The bench raises a write request in the middle of a read's strobe window. It later reads the target address and expects the never-written value. A matching case holds a request high across the release cycle. That request has to wait through the idle gap before it is taken. The bench's memory model returns a filler pattern on lanes that were not requested. This shows that the lane masking on the read result is done by the controller itself.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_END    = 2'd3
  } xfer_state_e;

  // Number of strobe cycles covering the access time, never below one.
  function automatic int unsigned wait_cycles(input int unsigned acc_ps,
                                              input int unsigned clk_ps);
    int unsigned w;
    w = (acc_ps + clk_ps - 1) / clk_ps;
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned WAIT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  output logic last
);
  localparam int unsigned CNT_W = (WAIT < 2) ? 1 : $clog2(WAIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last = (cnt_q == CNT_W'(WAIT - 1));

  always_comb begin
    cnt_en = load | (en & ~last);
    cnt_d  = load ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sram_xfer_seq.sv
module sram_xfer_seq
  import sram_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wait_last,
  output xfer_state_e state_q,
  output xfer_state_e state_d,
  output logic        accept,
  output logic        capture
);
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        accept  = 1'b1;
        state_d = ST_SETUP;
      end
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (wait_last) begin
        capture = 1'b1;
        state_d = ST_END;
      end
      ST_END:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  xfer_state_e       state_d,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata
);
  // Latched request, loaded on acceptance.
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= req_we;
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  // Control pins are registered from the next state so they never glitch.
  logic             sel_we, busy_d;
  logic [LANES-1:0] sel_be;
  logic             ce_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [LANES-1:0] lane_n_d;

  always_comb begin
    sel_we   = accept ? req_we : we_q;
    sel_be   = accept ? req_be : be_q;
    busy_d   = (state_d != ST_IDLE);
    ce_n_d   = ~busy_d;
    we_n_d   = ~((state_d == ST_ACCESS) & sel_we);
    oe_n_d   = ~((state_d == ST_ACCESS) & ~sel_we);
    lane_n_d = busy_d ? ~sel_be : '1;
    dq_oe_d  = busy_d & sel_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lane_n <= '1;
      mem_dq_oe  <= 1'b0;
    end else begin
      mem_ce_n   <= ce_n_d;
      mem_we_n   <= we_n_d;
      mem_oe_n   <= oe_n_d;
      mem_lane_n <= lane_n_d;
      mem_dq_oe  <= dq_oe_d;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;

  // Read result path with per-lane masking.
  logic [DATA_W-1:0] lane_mask, rdata_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  assign rdata_d = we_q ? '0 : (mem_dq_i & lane_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy <= 1'b0;
    else        rdy <= capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= rdata_d;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned ACCESS_PS = 45000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rdy,
  output logic [DATA_W-1:0]     rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned WAIT_CYC = wait_cycles(ACCESS_PS, CLK_PS);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  xfer_state_e state_q, state_d;
  logic        accept, capture, wait_last;

  sram_xfer_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req       (req),
    .wait_last (wait_last),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .capture   (capture)
  );

  sram_wait_timer #(.WAIT(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (state_q == ST_SETUP),
    .en    (state_q == ST_ACCESS),
    .last  (wait_last)
  );

  sram_pin_stage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .accept     (accept),
    .capture    (capture),
    .state_d    (state_d),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .mem_dq_i   (mem_dq_i),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .rdy        (rdy),
    .rdata      (rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LANES     = 2,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned ACCESS_PS = 45000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic              mem_dq_oe
);
  localparam int unsigned WAIT = sram_ctrl_pkg::wait_cycles(ACCESS_PS, CLK_PS);
  localparam int unsigned CW   = $clog2(WAIT + 2);

  // Length of the current strobe-low run.
  logic [CW-1:0] lowcnt_q;
  logic          strobe_lo;
  assign strobe_lo = ~mem_we_n | ~mem_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       lowcnt_q <= '0;
    else if (!strobe_lo)              lowcnt_q <= '0;
    else if (lowcnt_q != {CW{1'b1}})  lowcnt_q <= lowcnt_q + CW'(1);
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && (&mem_lane_n) && !mem_dq_oe));

  p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) || $rose(mem_oe_n)) |-> (lowcnt_q == CW'(WAIT)));

  p_we_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe)));

  p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_idle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> mem_ce_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .LANES     (DATA_W / 8),
  .CLK_PS    (CLK_PS),
  .ACCESS_PS (ACCESS_PS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdy        (rdy),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_lane_n (mem_lane_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
  localparam int W = (45000 + 4000 - 1) / 4000;  // 12 strobe cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rdy, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic [1:0]  mem_lane_n;

  always #2 clk = ~clk;

  sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: writes land on the rising write strobe.
  logic [15:0] ext_mem [int];
  logic [15:0] shadow  [int];

  function automatic logic [15:0] ext_rd(input logic [15:0] a);
    return ext_mem.exists(int'(a)) ? ext_mem[int'(a)] : 16'h0000;
  endfunction

  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0) begin
      logic [15:0] w;
      w = ext_rd(mem_addr);
      if (!mem_lane_n[0]) w[7:0]  = mem_dq_o[7:0];
      if (!mem_lane_n[1]) w[15:8] = mem_dq_o[15:8];
      ext_mem[int'(mem_addr)] = w;
    end
  end

  // Unselected lanes and idle bus return filler to expose missing masking.
  always @* begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      mem_dq_i[7:0]  = mem_lane_n[0] ? 8'hA5 : ext_rd(mem_addr)[7:0];
      mem_dq_i[15:8] = mem_lane_n[1] ? 8'hA5 : ext_rd(mem_addr)[15:8];
    end else begin
      mem_dq_i = 16'h5A5A;
    end
  end

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop plus pin-level protocol checks.
  int  lo_run = 0;
  bit  prev_we_n = 1'b1, prev_ce_n = 1'b1, prev_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected rdy", 32'(rdata), 32'hx);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rdata === e, t, 32'(rdata), 32'(e));
        end
      end
      if (!mem_we_n || !mem_oe_n) lo_run++;
      else if (lo_run != 0) begin
        check(lo_run == W, "R2 strobe length", 32'(lo_run), 32'(W));
        lo_run = 0;
      end
      if (!mem_we_n && prev_we_n)
        check(!prev_ce_n && prev_dq_oe, "R3 write setup", {prev_ce_n, prev_dq_oe}, 2'b01);
      if (!mem_we_n) check(mem_oe_n, "R3 oe high in write", 32'(mem_oe_n), 1);
      if (mem_dq_oe)
        check(mem_oe_n && !mem_ce_n, "R7 bus drive", {mem_oe_n, mem_ce_n}, 2'b10);
      prev_we_n  = mem_we_n;
      prev_ce_n  = mem_ce_n;
      prev_dq_oe = mem_dq_oe;
    end
  end

  // Driver: called at a falling edge, holds req for hold_cyc cycles.
  task automatic drive(input bit we, input logic [15:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input int hold_cyc, input bit push,
                       input string tag);
    logic [15:0] m, old;
    m   = {{8{be[1]}}, {8{be[0]}}};
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (push) begin
      if (we) begin
        shadow[int'(a)] = (old & ~m) | (wd & m);
        exp_q.push_back(16'h0000);
      end else begin
        exp_q.push_back(old & m);
      end
      tag_q.push_back(tag);
    end
    req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    repeat (hold_cyc) @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 1;
    while (!rdy) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic xfer(input bit we, input logic [15:0] a, input logic [1:0] be,
                      input logic [15:0] wd, input string tag);
    int n;
    @(negedge clk);
    drive(we, a, be, wd, 1, 1'b1, tag);
    wait_rdy(n);
    check(n == W + 2, "R9 latency", 32'(n), 32'(W + 2));
    @(negedge clk);
    check(mem_ce_n, "R8 idle gap", 32'(mem_ce_n), 1);
  endtask

  bit done = 1'b0;

  initial begin
    int n;
    repeat (5) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_oe && !rdy,
          "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, rdy},
          7'b1111100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_ce_n && mem_lane_n == 2'b11 && !rdy, "R1 idle after reset",
          {mem_ce_n, mem_lane_n, rdy}, 4'b1110);

    xfer(1'b1, 16'h0010, 2'b11, 16'h1234, "R6 write result");
    xfer(1'b0, 16'h0010, 2'b11, 16'h0000, "R5 full read");
    xfer(1'b1, 16'h0010, 2'b01, 16'hABCD, "R6 write result");
    xfer(1'b0, 16'h0010, 2'b11, 16'h0000, "R5 low lane write");
    xfer(1'b1, 16'h0010, 2'b10, 16'h7788, "R6 write result");
    xfer(1'b0, 16'h0010, 2'b11, 16'h0000, "R5 high lane write");
    xfer(1'b0, 16'h0010, 2'b01, 16'h0000, "R6 low lane read");
    xfer(1'b0, 16'h0010, 2'b10, 16'h0000, "R6 high lane read");
    xfer(1'b1, 16'h0010, 2'b00, 16'hFFFF, "R6 no-lane write");
    xfer(1'b0, 16'h0010, 2'b11, 16'h0000, "R6 no-lane write kept word");
    xfer(1'b0, 16'h0010, 2'b00, 16'h0000, "R6 no-lane read");
    xfer(1'b1, 16'h0000, 2'b11, 16'hC0DE, "R6 write result");
    xfer(1'b1, 16'hFFFF, 2'b11, 16'hBEEF, "R6 write result");
    xfer(1'b0, 16'h0000, 2'b11, 16'h0000, "R5 addr low bound");
    xfer(1'b0, 16'hFFFF, 2'b11, 16'h0000, "R5 addr high bound");

    // R8: request raised mid-transfer must be dropped.
    @(negedge clk);
    drive(1'b0, 16'h0010, 2'b11, 16'h0000, 1, 1'b1, "R4 read under interference");
    repeat (4) @(negedge clk);
    drive(1'b1, 16'h0020, 2'b11, 16'hDEAD, 1, 1'b0, "");
    wait_rdy(n);
    // R8: request held through the release cycle waits for the idle gap.
    drive(1'b1, 16'h0030, 2'b11, 16'h4242, 2, 1'b1, "R6 back-to-back write");
    wait_rdy(n);
    check(n == W + 2, "R8 held request accepted after gap", 32'(n), 32'(W + 2));
    @(negedge clk);
    xfer(1'b0, 16'h0020, 2'b11, 16'h0000, "R8 ignored write left memory");
    xfer(1'b0, 16'h0030, 2'b11, 16'h0000, "R8 back-to-back readback");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule